// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise and Framing Detection

This block receives asynchronous serial characters. It samples the line once on each pulse of a strobe that runs at sixteen times the baud rate, so each bit time is split into sixteen slots numbered 1 to 16. A start bit is recognised on a falling edge and then confirmed by a vote of three early samples. Each following bit is decided by a majority of three samples taken at the middle of the bit. Falling edges found during a character pull the slot counter back into line with the transmitter. This lets the block tolerate a moderate baud mismatch.

A received character goes into a single holding register together with its noise and framing status. A full indication tells the consumer that a character is waiting. A character that arrives while the register is still full is discarded and raises an overrun indication. The consumer releases the register with a two-step handshake: a status read strobe while the register is full, then a data read strobe. The line polarity can be inverted. Characters carry either eight or nine data bits.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, and whenever `rx_en` is low, no character is accepted. After reset, `data_o`, `full_o`, `overrun_o`, `noise_o` and `frame_err_o` are all 0.
- R2: A start candidate is a 0 sample directly after three 1 samples; that 0 sample is slot 1. The candidate is kept only if at least two of the samples at slots 3, 5 and 7 are 0. Otherwise it is dropped and nothing is delivered.
- R3: Data bits arrive least significant bit first. Each bit is set to the majority of its samples at slots 8, 9 and 10. With `nine_bit` = 0 there are eight data bits and `data_o[8]` reads 0. With `nine_bit` = 1 there are nine data bits.
- R4: A start bit that passed the slot 3/5/7 vote counts as 0, even when its slot 8–10 samples read 1.
- R5: `noise_o` is set with the character when any sample used for any bit of the frame (start, data or stop) differs from the value decided for that bit.
- R6: A stop bit decided as 0 sets `frame_err_o`. The character is still delivered. A frame whose data bits and stop bit are all 0 is a break: it is delivered as data 0 with `frame_err_o` = 1.
- R7: After a framing error that is not a break, the edge history is refilled with three 1 samples. A 0 sample right after the stop decision (slot 11 of the stop bit) starts a new character.
- R8: During data and stop bits, a falling edge seen when the next slot would be below 8 realigns that slot to 1 within the same bit. A falling edge seen when the next slot would be above 10 starts the next bit at slot 1.
- R9: The character is handed over at the slot-10 sample of the stop bit. If the register is empty, `full_o` rises on that clock edge.
- R10: A character that completes while `full_o` is 1 is discarded. It sets `overrun_o`, and `data_o` keeps the earlier character.
- R11: A `rd_data` strobe clears `full_o`, `overrun_o`, `noise_o` and `frame_err_o`, but only when it follows a `rd_status` strobe given while `full_o` was 1. A `rd_data` strobe without that earlier status read has no effect.
- R12: With `rx_inv` = 1 the line is complemented before sampling. An idle line is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| rx_inv | input | 1 | Complement the serial line before sampling |
| nine_bit | input | 1 | 1 selects nine data bits, 0 selects eight |
| tick16 | input | 1 | One-cycle strobe at sixteen times the baud rate |
| rxd | input | 1 | Serial data line |
| rd_status | input | 1 | Status read strobe (first step of release) |
| rd_data | input | 1 | Data read strobe (second step of release) |
| data_o | output | DATA_W | Received character |
| full_o | output | 1 | Holding register contains a character |
| overrun_o | output | 1 | A character was lost while full |
| noise_o | output | 1 | Held character had a disagreeing sample |
| frame_err_o | output | 1 | Held character had a 0 stop bit |

## Verification
The bench builds the block with the default `DATA_W` = 9. Because of that, both character lengths can be reached at run time through `nine_bit`. The sample strobe is given once every four clocks, and the bench writes every sample slot directly. This lets it place a flipped sample in a chosen slot and stretch or shorten bit times to 19 or 14 slots to exercise realignment. It also lets it cut a stop bit after slot 10 to test the history refill.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
    // sample slots per bit time
    localparam int OSR    = 16;
    localparam int SLOT_W = $clog2(OSR + 1);
    // start qualification slots
    localparam int QUAL_A = 3;
    localparam int QUAL_B = 5;
    localparam int QUAL_C = 7;
    // majority vote slots
    localparam int VOTE_A = 8;
    localparam int VOTE_B = 9;
    localparam int VOTE_C = 10;
    // depth of the edge history
    localparam int HIST_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_BITS = 2'd2
    } rx_state_e;
endpackage

// File: rtl/uart_os_rx_front.sv
module uart_os_rx_front
    import uart_os_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic rxd_i,
    input  logic inv_i,
    input  logic preload_i,
    output logic samp_o,
    output logic edge_o
);
    localparam logic [HIST_W-1:0] ALL_ONES = {HIST_W{1'b1}};

    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        samp_o = rxd_i ^ inv_i;
        edge_o = tick_i && !samp_o && (hist_q == ALL_ONES);
        hist_d = hist_q;
        if (!en_i) begin
            hist_d = '0;
        end else if (tick_i) begin
            if (preload_i) begin
                hist_d = ALL_ONES;
            end else begin
                hist_d = {hist_q[HIST_W-2:0], samp_o};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    // R7: a refill request leaves the history able to see an edge at once
    p_refill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && preload_i) |=> (hist_q == ALL_ONES));

    // R1: disabled receiver holds an empty history
    p_hist_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (hist_q == '0));
endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              nine_i,
    input  logic              tick_i,
    input  logic              samp_i,
    input  logic              edge_i,
    output logic              xfer_o,
    output logic [DATA_W-1:0] xdata_o,
    output logic              xnf_o,
    output logic              xfe_o,
    output logic              preload_o
);
    localparam int IDX_W = $clog2(DATA_W + 2);
    localparam logic [SLOT_W-1:0] S_ONE = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] S_END = SLOT_W'(OSR);
    localparam logic [SLOT_W-1:0] S_QA  = SLOT_W'(QUAL_A);
    localparam logic [SLOT_W-1:0] S_QB  = SLOT_W'(QUAL_B);
    localparam logic [SLOT_W-1:0] S_QC  = SLOT_W'(QUAL_C);
    localparam logic [SLOT_W-1:0] S_VA  = SLOT_W'(VOTE_A);
    localparam logic [SLOT_W-1:0] S_VB  = SLOT_W'(VOTE_B);
    localparam logic [SLOT_W-1:0] S_VC  = SLOT_W'(VOTE_C);
    localparam logic [IDX_W-1:0]  I_ONE   = IDX_W'(1);
    localparam logic [IDX_W-1:0]  I_STOP8 = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0]  I_STOP9 = IDX_W'(DATA_W + 1);

    typedef struct packed {
        rx_state_e          st;
        logic [SLOT_W-1:0]  slot;
        logic [IDX_W-1:0]   idx;
        logic [1:0]         qz;
        logic [1:0]         ones;
        logic               noise;
        logic [DATA_W-1:0]  data;
    } frame_t;

    frame_t q, n;

    logic [SLOT_W-1:0] slot_up, cand;
    logic              wrap, adv, vote, dis;
    logic [1:0]        ones_t, zsum;
    logic [IDX_W-1:0]  stop_idx;

    always_comb begin
        n         = q;
        xfer_o    = 1'b0;
        xnf_o     = 1'b0;
        xfe_o     = 1'b0;
        preload_o = 1'b0;
        xdata_o   = q.data;
        stop_idx  = nine_i ? I_STOP9 : I_STOP8;
        slot_up   = q.slot + S_ONE;
        wrap      = (q.slot == S_END);
        cand      = wrap ? S_ONE : slot_up;
        adv       = wrap;
        ones_t    = q.ones + {1'b0, samp_i};
        vote      = ones_t[1];
        zsum      = q.qz + {1'b0, !samp_i};
        if (q.idx == '0) begin
            dis = (ones_t != 2'd0);
        end else begin
            dis = (ones_t != 2'd0) && (ones_t != 2'd3);
        end

        if (!en_i) begin
            n = '0;
        end else if (tick_i) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (edge_i) begin
                        n      = '0;
                        n.st   = ST_QUAL;
                        n.slot = S_ONE;
                    end
                end
                ST_QUAL: begin
                    n.slot = slot_up;
                    if (slot_up == S_QA || slot_up == S_QB || slot_up == S_QC) begin
                        if (!samp_i) begin
                            n.qz = zsum;
                        end else begin
                            n.noise = 1'b1;
                        end
                    end
                    if (slot_up == S_QC) begin
                        n.st = (zsum >= 2'd2) ? ST_BITS : ST_IDLE;
                    end
                end
                ST_BITS: begin
                    if (q.idx != '0 && edge_i) begin
                        if (!wrap && cand > S_VC) begin
                            adv  = 1'b1;
                            cand = S_ONE;
                        end else if (cand < S_VA) begin
                            cand = S_ONE;
                        end
                    end
                    n.slot = cand;
                    if (adv) begin
                        n.idx  = q.idx + I_ONE;
                        n.ones = 2'd0;
                    end else if (cand == S_VA || cand == S_VB) begin
                        n.ones = ones_t;
                    end else if (cand == S_VC) begin
                        n.noise = q.noise | dis;
                        if (q.idx != '0 && q.idx != stop_idx) begin
                            n.data[q.idx - I_ONE] = vote;
                        end
                        if (q.idx == stop_idx) begin
                            xfer_o    = 1'b1;
                            xnf_o     = q.noise | dis;
                            xfe_o     = !vote;
                            preload_o = !vote && (q.data != '0);
                            n         = '0;
                        end
                    end
                end
                default: n = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    // R8: an active frame always holds a valid slot number
    p_slot_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> (q.slot >= S_ONE && q.slot <= S_END));

    // R2: a frame only opens on a low sample from the front end
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && q.st == ST_IDLE && n.st == ST_QUAL) |-> !samp_i);

    // R1: disabling drops any frame in progress
    p_disable_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.st == ST_IDLE));

    // R9: two hand-overs can never be back to back
    p_xfer_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> !xfer_o);
endmodule

// File: rtl/uart_os_rx_buf.sv
module uart_os_rx_buf #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_i,
    input  logic [DATA_W-1:0] xdata_i,
    input  logic              xnf_i,
    input  logic              xfe_i,
    input  logic              rd_status_i,
    input  logic              rd_data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              nf_o,
    output logic              fe_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              nf;
        logic              fe;
        logic              armed;
    } buf_t;

    buf_t q, n;
    logic clr, full_eff;

    always_comb begin
        n        = q;
        clr      = rd_data_i && q.armed;
        full_eff = q.full && !clr;
        if (rd_status_i && q.full) begin
            n.armed = 1'b1;
        end
        if (clr) begin
            n.full  = 1'b0;
            n.ovr   = 1'b0;
            n.nf    = 1'b0;
            n.fe    = 1'b0;
            n.armed = 1'b0;
        end
        if (xfer_i) begin
            if (!full_eff) begin
                n.data = xdata_i;
                n.full = 1'b1;
                n.nf   = xnf_i;
                n.fe   = xfe_i;
            end else begin
                n.ovr = 1'b1;
            end
        end
        data_o = q.data;
        full_o = q.full;
        ovr_o  = q.ovr;
        nf_o   = q.nf;
        fe_o   = q.fe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    // R10: overrun can only be reported alongside a held character
    p_ovr_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |-> q.full);

    // R10: held data is untouched until a release
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !clr) |=> (q.full && $stable(q.data)));

    // R11: status flags never outlive the held character
    p_flags_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !q.full |-> (!q.nf && !q.fe));

    // R11: a data read without the status step leaves the register full
    p_lone_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_i && !q.armed && q.full) |=> q.full);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              rx_inv,
    input  logic              nine_bit,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              rd_status,
    input  logic              rd_data,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              overrun_o,
    output logic              noise_o,
    output logic              frame_err_o
);
    logic              samp, edge_seen, preload;
    logic              xfer, xnf, xfe;
    logic [DATA_W-1:0] xdata;

    uart_os_rx_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_en),
        .tick_i    (tick16),
        .rxd_i     (rxd),
        .inv_i     (rx_inv),
        .preload_i (preload),
        .samp_o    (samp),
        .edge_o    (edge_seen)
    );

    uart_os_rx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_en),
        .nine_i    (nine_bit),
        .tick_i    (tick16),
        .samp_i    (samp),
        .edge_i    (edge_seen),
        .xfer_o    (xfer),
        .xdata_o   (xdata),
        .xnf_o     (xnf),
        .xfe_o     (xfe),
        .preload_o (preload)
    );

    uart_os_rx_buf #(.DATA_W(DATA_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_i      (xfer),
        .xdata_i     (xdata),
        .xnf_i       (xnf),
        .xfe_i       (xfe),
        .rd_status_i (rd_status),
        .rd_data_i   (rd_data),
        .data_o      (data_o),
        .full_o      (full_o),
        .ovr_o       (overrun_o),
        .nf_o        (noise_o),
        .fe_o        (frame_err_o)
    );
endmodule

// File: tb/uart_os_rx_tb_top.sv
`timescale 1ns/1ps
module uart_os_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rx_inv = 1'b0;
    logic       nine_bit = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       mon_st = 1'b0, mon_dt = 1'b0, man_st = 1'b0, man_dt = 1'b0;
    logic       rd_status, rd_data;
    logic [8:0] data_o;
    logic       full_o, overrun_o, noise_o, frame_err_o;
    bit         inv_drv = 1'b0;
    bit         auto_rd = 1'b1;
    int         n_checks = 0;
    int         n_fail = 0;

    typedef struct {
        logic [8:0] d;
        bit         nf;
        bit         fe;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    assign rd_status = mon_st | man_st;
    assign rd_data   = mon_dt | man_dt;

    always #4 clk = ~clk;

    uart_os_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_inv(rx_inv),
        .nine_bit(nine_bit), .tick16(tick16), .rxd(rxd),
        .rd_status(rd_status), .rd_data(rd_data), .data_o(data_o),
        .full_o(full_o), .overrun_o(overrun_o), .noise_o(noise_o),
        .frame_err_o(frame_err_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // one sample slot: line value presented together with the strobe
    task automatic put(input bit v);
        @(negedge clk);
        rxd = v ^ inv_drv;
        tick16 = 1'b1;
        @(negedge clk);
        tick16 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b1);
    endtask

    task automatic send_bit(input bit v, input int len, input int fmask);
        for (int s = 1; s <= len; s++) put(v ^ fmask[s-1]);
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input bit stopv,
                              input int blen, input int slen, input int fbit,
                              input int fmask);
        send_bit(1'b0, blen, (fbit == 0) ? fmask : 0);
        for (int i = 0; i < nb; i++) send_bit(d[i], blen, (fbit == i + 1) ? fmask : 0);
        send_bit(stopv, slen, (fbit == nb + 1) ? fmask : 0);
    endtask

    task automatic expect_item(input logic [8:0] d, input bit nf, input bit fe,
                               input string tag);
        exp_t e;
        e.d = d; e.nf = nf; e.fe = fe; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic man_read(input bit st, input bit dt);
        if (st) begin
            @(negedge clk); man_st = 1'b1;
            @(negedge clk); man_st = 1'b0;
        end
        if (dt) begin
            @(negedge clk); man_dt = 1'b1;
            @(negedge clk); man_dt = 1'b0;
        end
        @(negedge clk);
    endtask

    // scoreboard monitor: pops the expected item when a character appears
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && auto_rd && full_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected character", int'(data_o), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(data_o == e.d, e.tag, "data", int'(data_o), int'(e.d));
                    check(noise_o == e.nf, e.tag, "noise R5", int'(noise_o), int'(e.nf));
                    check(frame_err_o == e.fe, e.tag, "frame R6", int'(frame_err_o), int'(e.fe));
                    check(overrun_o == 1'b0, e.tag, "overrun R10", int'(overrun_o), 0);
                end
                @(negedge clk); mon_st = 1'b1;
                @(negedge clk); mon_st = 1'b0; mon_dt = 1'b1;
                @(negedge clk); mon_dt = 1'b0;
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(data_o == 9'h0, "R1", "data after reset", int'(data_o), 0);
        check(full_o == 1'b0, "R1", "full after reset", int'(full_o), 0);
        check(overrun_o == 1'b0, "R1", "overrun after reset", int'(overrun_o), 0);
        check(noise_o == 1'b0, "R1", "noise after reset", int'(noise_o), 0);
        check(frame_err_o == 1'b0, "R1", "frame after reset", int'(frame_err_o), 0);
        rst_n = 1'b1;
        rx_en = 1'b1;
        idle(8);

        // R3 / R9: clean 8-bit characters
        expect_item(9'h0A5, 0, 0, "R3"); send_frame(9'h0A5, 8, 1, 16, 16, -1, 0); idle(4);
        expect_item(9'h03C, 0, 0, "R9"); send_frame(9'h03C, 8, 1, 16, 16, -1, 0); idle(4);
        expect_item(9'h0FF, 0, 0, "R3"); send_frame(9'h0FF, 8, 1, 16, 16, -1, 0); idle(4);
        expect_item(9'h000, 0, 0, "R3"); send_frame(9'h000, 8, 1, 16, 16, -1, 0); idle(4);

        // R3: nine-bit characters
        nine_bit = 1'b1;
        expect_item(9'h1A5, 0, 0, "R3"); send_frame(9'h1A5, 9, 1, 16, 16, -1, 0); idle(4);
        expect_item(9'h0FF, 0, 0, "R3"); send_frame(9'h0FF, 9, 1, 16, 16, -1, 0); idle(4);
        nine_bit = 1'b0;

        // R5: one flipped sample at slot 9 of data bit 2
        expect_item(9'h05A, 1, 0, "R5"); send_frame(9'h05A, 8, 1, 16, 16, 3, 1 << 8); idle(4);
        // R3: slots 8 and 9 of data bit 3 flipped outvote slot 10
        expect_item(9'h052, 1, 0, "R3"); send_frame(9'h05A, 8, 1, 16, 16, 4, 3 << 7); idle(4);
        // R2: start with slot 3 high still qualifies
        expect_item(9'h033, 1, 0, "R2"); send_frame(9'h033, 8, 1, 16, 16, 0, 1 << 2); idle(4);
        // R4: start bit reading high at slots 8-10 still counts as 0
        expect_item(9'h066, 1, 0, "R4"); send_frame(9'h066, 8, 1, 16, 16, 0, 7 << 7); idle(4);
        // R5: noise in the stop bit
        expect_item(9'h081, 1, 0, "R5"); send_frame(9'h081, 8, 1, 16, 16, 9, 1 << 9); idle(4);

        // R2: short glitch and failed slot 3/5/7 vote are dropped
        put(1'b0); put(1'b0); idle(30);
        send_bit(1'b0, 7, (1 << 2) | (1 << 4)); idle(30);
        check(full_o == 1'b0, "R2", "rejected start delivered", int'(full_o), 0);

        // R6 / R7: framing error, new start at slot 11 of the stop bit
        expect_item(9'h055, 0, 1, "R6"); expect_item(9'h03C, 0, 0, "R7");
        send_frame(9'h055, 8, 0, 16, 10, -1, 0);
        send_frame(9'h03C, 8, 1, 16, 16, -1, 0); idle(6);

        // R6: break character, then long low line yields nothing more
        expect_item(9'h000, 0, 1, "R6");
        send_frame(9'h000, 8, 0, 16, 16, -1, 0);
        for (int i = 0; i < 20; i++) put(1'b0);
        idle(40);
        check(exp_q.size() == 0, "R6", "pending items after break", exp_q.size(), 0);

        // R12: inverted line
        @(negedge clk); rx_inv = 1'b1; inv_drv = 1'b1;
        idle(8);
        expect_item(9'h0C3, 0, 0, "R12"); send_frame(9'h0C3, 8, 1, 16, 16, -1, 0); idle(6);
        check(rxd == 1'b0, "R12", "idle line level", int'(rxd), 0);
        @(negedge clk); rx_inv = 1'b0; inv_drv = 1'b0;
        idle(8);

        // R8: slow (19-slot) and fast (14-slot) transmitters
        expect_item(9'h055, 0, 0, "R8"); send_frame(9'h055, 8, 1, 19, 19, -1, 0); idle(6);
        expect_item(9'h055, 0, 0, "R8"); send_frame(9'h055, 8, 1, 14, 14, -1, 0); idle(6);

        // R10 / R11: overrun and two-step release
        auto_rd = 1'b0;
        send_frame(9'h011, 8, 1, 16, 16, -1, 0); idle(2);
        check(full_o == 1'b1, "R9", "full after first", int'(full_o), 1);
        send_frame(9'h022, 8, 1, 16, 16, -1, 0); idle(2);
        check(overrun_o == 1'b1, "R10", "overrun", int'(overrun_o), 1);
        check(data_o == 9'h011, "R10", "data kept", int'(data_o), 'h11);
        man_read(1'b0, 1'b1);
        check(full_o == 1'b1, "R11", "full after lone data read", int'(full_o), 1);
        check(overrun_o == 1'b1, "R11", "overrun after lone data read", int'(overrun_o), 1);
        man_read(1'b1, 1'b1);
        check(full_o == 1'b0, "R11", "full after two-step", int'(full_o), 0);
        check(overrun_o == 1'b0, "R11", "overrun after two-step", int'(overrun_o), 0);
        auto_rd = 1'b1;

        // R1: disabled receiver ignores a frame
        @(negedge clk); rx_en = 1'b0;
        send_frame(9'h077, 8, 1, 16, 16, -1, 0); idle(4);
        check(full_o == 1'b0, "R1", "full while disabled", int'(full_o), 0);
        @(negedge clk); rx_en = 1'b1;
        idle(8);
        expect_item(9'h09C, 0, 0, "R1"); send_frame(9'h09C, 8, 1, 16, 16, -1, 0); idle(8);

        check(exp_q.size() == 0, "R9", "undelivered characters", exp_q.size(), 0);
        finish_run();
    end
endmodule